// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a serial audio bit stream into parallel sample words. It runs entirely on the rising edge of the bit clock, which is its only clock. At every edge it samples the frame clock and the serial data line. A two-bit format select picks one of three framings. In left-justified framing each word starts at a frame-clock change. In right-justified framing each word ends at a frame-clock change. In the multiplexed framing a frame-clock rising edge starts a burst of six back-to-back words, which are three left/right pairs.

A second two-bit select sets the word length to 16, 20, 24 or 32 bits. Each finished word is presented right-aligned on a parallel output, together with a channel index and a one-cycle valid strobe. The block assumes that both selects are changed only while reset is asserted. It also assumes that the serial source changes its lines away from the bit-clock rising edge.

Top module: `audio_rx_deser`

## Requirements
- R1: After a synchronous active-low reset, `word_valid` is low and `word_data` and `word_chan` are zero. No word is reported before the frame clock has changed.
- R2: Format code 0 (left-justified): the MSB is the data bit sampled at the first rising edge at which the sampled frame clock differs from the previous sample. The next N-1 samples complete the word, and `word_valid` rises right after the edge that sampled the LSB.
- R3: In format codes 0 and 1, a word sent while the frame clock is high is reported on channel 0 (left), and a word sent while it is low is reported on channel 1 (right).
- R4: In format code 0, data bits sampled after the Nth bit and before the next frame-clock change have no effect on any output.
- R5: Format code 1 (right-justified): when a frame-clock change is sampled, the N data bits sampled at the N edges just before it form the word, LSB last. `word_valid` rises right after the edge that sampled the change. Earlier bits in the same half-frame are discarded.
- R6: In format code 1, the channel comes from the frame-clock level held during the word, not the level after the change.
- R7: In format code 1, the first frame-clock change after reset produces no word.
- R8: Format code 2 (multiplexed): a sampled frame-clock rising edge marks the MSB of channel 0. Channels 1 to 5 follow back to back, N bits each. A rising edge in the middle of a burst restarts it at channel 0.
- R9: In format code 2, frame-clock falling edges and any bits after the sixth word have no effect, and the frame clock may stay high or low for any number of cycles.
- R10: Length code 0/1/2/3 selects N = 16/20/24/32. Words are right-aligned, and bits at and above N read as zero.
- R11: `word_valid` is high for exactly one cycle per finished word. `word_data` and `word_chan` are valid in that cycle.
- R12: Format code 3 disables the block: `word_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 six-channel multiplexed, 3 off |
| len_sel | input | 2 | Word length: 0→16, 1→20, 2→24, 3→32 bits |
| frame_clk | input | 1 | Frame clock (left/right select or frame sync) |
| ser_data | input | 1 | Serial data, MSB first |
| word_data | output | 32 | Received word, right-aligned |
| word_chan | output | 3 | Channel index of the word |
| word_valid | output | 1 | One-cycle strobe for a finished word |

## Verification
In left-justified and multiplexed framing, a word is due in the cycle right after the rising edge that sampled its LSB. In right-justified framing it is due one edge later, right after the edge that first samples the changed frame clock. The bench drives every bit on a falling edge and records the number of the rising edge that will sample it. Its behavioural model tags each expected word with that edge number. On every falling edge the outputs are compared with the model: a word must appear exactly in its due cycle, and no strobe may appear in any other cycle.

// File: rtl/audio_rx_pkg.sv
// Package: shared encodings and sizing helpers for the audio receiver.
// Assumes: word lengths never exceed 32 bits.
package audio_rx_pkg;

    // Framing selected by fmt_sel.
    typedef enum logic [1:0] {
        FMT_LEFT  = 2'd0,
        FMT_RIGHT = 2'd1,
        FMT_MUX   = 2'd2,
        FMT_OFF   = 2'd3
    } fmt_e;

    // Number of channels in one multiplexed burst (three left/right pairs).
    localparam int MUX_CHANNELS = 6;

    // Bits per word for a length code.
    function automatic int len_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/audio_rx_edge.sv
// Module: frame-clock change detector.
// Registers the frame clock on every bit-clock rising edge and compares the
// new sample with the previous one. The register keeps tracking while reset
// is asserted, so no false change is seen when reset is released.
module audio_rx_edge (
    input  logic bclk,
    input  logic frame_clk,
    output logic fc_prev,
    output logic fc_change,
    output logic fc_rise
);

    // Purpose: hold the frame-clock sample taken at the previous edge.
    always_ff @(posedge bclk) begin
        fc_prev <= frame_clk;
    end

    // Purpose: flag any change and a rising change of the frame clock.
    always_comb begin
        fc_change = frame_clk ^ fc_prev;
        fc_rise   = frame_clk & ~fc_prev;
    end

endmodule

// File: rtl/audio_rx_shift.sv
// Module: serial history register and word extraction.
// Shifts the data line in MSB first. Presents two masked views: the N bits
// ending with the bit sampled now (used when a word ends on its LSB), and
// the N bits ending with the previous sample (used when a word ends at a
// frame-clock change). Bits at and above N are forced to zero.
module audio_rx_shift #(
    parameter int DW = 32,
    parameter int BW = $clog2(DW) + 1
) (
    input  logic          bclk,
    input  logic          rst_n,
    input  logic          ser_data,
    input  logic [BW-1:0] nbits,
    output logic [DW-1:0] word_now,
    output logic [DW-1:0] word_prev
);

    logic [DW-1:0] hist;

    // Purpose: shift one serial bit into the history on each edge.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[DW-2:0], ser_data};
        end
    end

    // One mask and select stage per output bit.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic keep;
        assign keep         = (BW'(i) < nbits);
        assign word_prev[i] = keep & hist[i];
        if (i == 0) begin : g_lsb
            assign word_now[i] = keep & ser_data;
        end else begin : g_upper
            assign word_now[i] = keep & hist[i-1];
        end
    end

endmodule

// File: rtl/audio_rx_seq.sv
// Module: framing sequencer.
// Decides when a word is complete and which channel it belongs to.
// Left-justified: counting restarts at every frame-clock change.
// Multiplexed: counting restarts at a rising change and runs through CHN words.
// Right-justified: a word completes at every change after the first one.
// Assumes fmt_sel and nbits are stable outside reset.
module audio_rx_seq
    import audio_rx_pkg::*;
#(
    parameter int CHN = MUX_CHANNELS,
    parameter int CW  = $clog2(CHN),
    parameter int BW  = 6
) (
    input  logic          bclk,
    input  logic          rst_n,
    input  logic [1:0]    fmt_sel,
    input  logic [BW-1:0] nbits,
    input  logic          frame_clk,
    input  logic          fc_prev,
    input  logic          fc_change,
    input  logic          fc_rise,
    output logic          done,
    output logic          use_prev,
    output logic [CW-1:0] chan
);

    fmt_e          fmt;
    logic          active;
    logic          seen;
    logic [BW-1:0] bit_cnt;
    logic [CW-1:0] chan_cnt;
    logic          start;
    logic          last_bit;

    // Purpose: decode the framing and the start and end of a word.
    always_comb begin
        fmt      = fmt_e'(fmt_sel);
        start    = ((fmt == FMT_LEFT) && fc_change) ||
                   ((fmt == FMT_MUX) && fc_rise);
        last_bit = (bit_cnt == nbits - BW'(1));
        use_prev = (fmt == FMT_RIGHT);
        done     = 1'b0;
        chan     = chan_cnt;
        case (fmt)
            FMT_LEFT, FMT_MUX: done = active && !start && last_bit;
            FMT_RIGHT: begin
                done = fc_change && seen;
                chan = fc_prev ? CW'(0) : CW'(1);
            end
            default: done = 1'b0;
        endcase
    end

    // Purpose: track bit position, channel number and first-change state.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            seen     <= 1'b0;
            bit_cnt  <= '0;
            chan_cnt <= '0;
        end else begin
            seen <= seen | fc_change;
            if (start) begin
                active   <= 1'b1;
                bit_cnt  <= BW'(1);
                chan_cnt <= (fmt == FMT_LEFT && !frame_clk) ? CW'(1) : CW'(0);
            end else if (active && last_bit) begin
                bit_cnt <= '0;
                if (fmt == FMT_MUX && chan_cnt != CW'(CHN - 1)) begin
                    chan_cnt <= chan_cnt + CW'(1);
                end else begin
                    active <= 1'b0;
                end
            end else if (active) begin
                bit_cnt <= bit_cnt + BW'(1);
            end
        end
    end

endmodule

// File: rtl/audio_rx_deser.sv
// Module: multi-format audio serial receiver (top).
// Combines change detection, the serial history and the framing sequencer,
// and registers each finished word with its channel and a one-cycle strobe.
// Assumes DW >= 32 so every length code fits; longer codes saturate at DW.
module audio_rx_deser
    import audio_rx_pkg::*;
#(
    parameter int DW  = 32,
    parameter int CHN = MUX_CHANNELS,
    parameter int CW  = $clog2(CHN)
) (
    input  logic          bclk,
    input  logic          rst_n,
    input  logic [1:0]    fmt_sel,
    input  logic [1:0]    len_sel,
    input  logic          frame_clk,
    input  logic          ser_data,
    output logic [DW-1:0] word_data,
    output logic [CW-1:0] word_chan,
    output logic          word_valid
);

    localparam int BW = $clog2(DW) + 1;

    logic [BW-1:0] nbits;
    logic          fc_prev;
    logic          fc_change;
    logic          fc_rise;
    logic [DW-1:0] word_now;
    logic [DW-1:0] word_prev;
    logic          done;
    logic          use_prev;
    logic [CW-1:0] chan;

    // Purpose: turn the length code into a bit count, limited to DW.
    always_comb begin
        nbits = (len_bits(len_sel) > DW) ? BW'(DW) : BW'(len_bits(len_sel));
    end

    audio_rx_edge u_edge (
        .bclk      (bclk),
        .frame_clk (frame_clk),
        .fc_prev   (fc_prev),
        .fc_change (fc_change),
        .fc_rise   (fc_rise)
    );

    audio_rx_shift #(.DW(DW), .BW(BW)) u_shift (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .ser_data  (ser_data),
        .nbits     (nbits),
        .word_now  (word_now),
        .word_prev (word_prev)
    );

    audio_rx_seq #(.CHN(CHN), .CW(CW), .BW(BW)) u_seq (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .fmt_sel   (fmt_sel),
        .nbits     (nbits),
        .frame_clk (frame_clk),
        .fc_prev   (fc_prev),
        .fc_change (fc_change),
        .fc_rise   (fc_rise),
        .done      (done),
        .use_prev  (use_prev),
        .chan      (chan)
    );

    // Purpose: register a finished word, its channel and the strobe.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            word_data  <= '0;
            word_chan  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= done;
            if (done) begin
                word_data <= use_prev ? word_prev : word_now;
                word_chan <= chan;
            end
        end
    end

endmodule

// File: rtl/audio_rx_deser_chk.sv
// Module: assertion checker for the receiver, bound to every instance.
// Assumes fmt_sel and len_sel change only under reset.
module audio_rx_deser_chk #(
    parameter int DW  = 32,
    parameter int CHN = 6,
    parameter int CW  = 3
) (
    input logic          bclk,
    input logic          rst_n,
    input logic [1:0]    fmt_sel,
    input logic [1:0]    len_sel,
    input logic [DW-1:0] word_data,
    input logic [CW-1:0] word_chan,
    input logic          word_valid
);

    logic [DW-1:0] low_mask;

    // Purpose: mask of the bits a word of the selected length may use.
    always_comb begin
        case (len_sel)
            2'd0:    low_mask = (DW'(1) << 16) - DW'(1);
            2'd1:    low_mask = (DW'(1) << 20) - DW'(1);
            2'd2:    low_mask = (DW'(1) << 24) - DW'(1);
            default: low_mask = {DW{1'b1}};
        endcase
    end

    assert_reset_quiet_R1: assert property (@(posedge bclk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (!word_valid && word_data == '0 && word_chan == '0));

    assert_lr_index_R3: assert property (@(posedge bclk) disable iff (!rst_n)
        (word_valid && fmt_sel[1] == 1'b0) |-> (word_chan <= CW'(1)));

    assert_mux_index_R8: assert property (@(posedge bclk) disable iff (!rst_n)
        (word_valid && fmt_sel == 2'd2) |-> (word_chan <= CW'(CHN - 1)));

    assert_word_width_R10: assert property (@(posedge bclk) disable iff (!rst_n)
        word_valid |-> ((word_data & ~low_mask) == '0));

    assert_off_silent_R12: assert property (@(posedge bclk) disable iff (!rst_n)
        (fmt_sel == 2'd3) |=> !word_valid);

endmodule

bind audio_rx_deser audio_rx_deser_chk #(.DW(DW), .CHN(CHN), .CW(CW)) u_chk (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .fmt_sel    (fmt_sel),
    .len_sel    (len_sel),
    .word_data  (word_data),
    .word_chan  (word_chan),
    .word_valid (word_valid)
);

// File: tb/tb_audio_rx_deser.sv
`timescale 1ns/1ps
module tb_audio_rx_deser;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [1:0]  len_sel = 2'd0;
    logic        frame_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [31:0] word_data;
    logic [2:0]  word_chan;
    logic        word_valid;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur_req = "R1";

    typedef struct {
        int          due;
        logic [31:0] w;
        int          ch;
    } exp_t;
    exp_t expq[$];

    // Behavioural model state.
    logic m_last_f;
    logic m_act;
    int   m_nb;
    int   m_ch;
    int   m_edges;
    logic [31:0] m_acc;
    logic bitq[$];

    audio_rx_deser dut (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .fmt_sel    (fmt_sel),
        .len_sel    (len_sel),
        .frame_clk  (frame_clk),
        .ser_data   (ser_data),
        .word_data  (word_data),
        .word_chan  (word_chan),
        .word_valid (word_valid)
    );

    always #2.5 bclk = ~bclk;
    always @(posedge bclk) cyc <= cyc + 1;

    function automatic int len_of(input logic [1:0] c);
        return (c == 2'd3) ? 32 : 16 + 4 * int'(c);
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s cycle %0d: actual=%h expected=%h", cur_req, what, cyc, act, exp);
        end
    endtask

    // Per-clock comparison against the model's expected words.
    always @(negedge bclk) begin
        if (expq.size() > 0 && expq[0].due == cyc) begin
            check(word_valid == 1'b1, "valid", 32'(word_valid), 32'd1);
            check(word_data == expq[0].w, "word", word_data, expq[0].w);
            check(int'(word_chan) == expq[0].ch, "chan", 32'(word_chan), 32'(expq[0].ch));
            void'(expq.pop_front());
        end else begin
            check(word_valid == 1'b0, "spurious valid", 32'(word_valid), 32'd0);
        end
    end

    task automatic do_reset(input logic [1:0] f, input logic [1:0] l);
        @(negedge bclk);
        rst_n = 1'b0; fmt_sel = f; len_sel = l; frame_clk = 1'b0; ser_data = 1'b0;
        repeat (2) @(negedge bclk);
        cur_req = "R1";
        check(word_data == '0, "reset word", word_data, 32'd0);
        check(word_chan == '0, "reset chan", 32'(word_chan), 32'd0);
        check(word_valid == 1'b0, "reset valid", 32'(word_valid), 32'd0);
        rst_n = 1'b1;
        expq.delete();
        bitq.delete();
        bitq.push_back(1'b0);   // sampled at the edge before the first send
        m_last_f = 1'b0; m_act = 1'b0; m_nb = 0; m_ch = 0; m_edges = 0; m_acc = '0;
    endtask

    // Drive one bit and advance the behavioural model for the edge that samples it.
    task automatic send(input logic f, input logic d);
        int n;
        int idx;
        bit chg;
        logic [31:0] w;
        @(negedge bclk);
        frame_clk = f; ser_data = d;
        idx = cyc + 1;
        n = len_of(len_sel);
        chg = (f != m_last_f);
        case (fmt_sel)
            2'd0: begin
                if (chg) begin
                    m_acc = 32'(d); m_nb = 1; m_ch = f ? 0 : 1; m_act = 1'b1;
                end else if (m_act) begin
                    m_acc = {m_acc[30:0], d}; m_nb++;
                end
                if (m_act && m_nb == n) begin
                    expq.push_back('{idx, m_acc, m_ch}); m_act = 1'b0;
                end
            end
            2'd2: begin
                if (chg && f) begin
                    m_acc = 32'(d); m_nb = 1; m_ch = 0; m_act = 1'b1;
                end else if (m_act) begin
                    m_acc = {m_acc[30:0], d}; m_nb++;
                end
                if (m_act && m_nb == n) begin
                    expq.push_back('{idx, m_acc, m_ch});
                    m_acc = '0; m_nb = 0; m_ch++;
                    if (m_ch == 6) m_act = 1'b0;
                end
            end
            2'd1: begin
                if (chg && m_edges > 0) begin
                    w = '0;
                    for (int k = 0; k < n; k++)
                        if (k < bitq.size()) w[k] = bitq[bitq.size() - 1 - k];
                    expq.push_back('{idx, w, m_last_f ? 0 : 1});
                end
            end
            default: ;
        endcase
        if (chg) m_edges++;
        bitq.push_back(d);
        if (bitq.size() > 32) void'(bitq.pop_front());
        m_last_f = f;
    endtask

    function automatic logic [31:0] rand_word(input int n);
        logic [31:0] r;
        r = $urandom;
        return (n == 32) ? r : (r & ((32'd1 << n) - 32'd1));
    endfunction

    // Left-justified halves: word first, then t-n filler bits.
    task automatic lj_run(input int t, input int halves);
        int n;
        logic [31:0] w;
        n = len_of(len_sel);
        for (int h = 0; h < halves; h++) begin
            w = rand_word(n);
            for (int i = 0; i < t; i++)
                send(h % 2 == 0, (i < n) ? w[n-1-i] : 1'($urandom));
        end
    endtask

    // Right-justified halves: t-n filler bits, then the word ending at the change.
    task automatic rj_run(input int t, input int halves);
        int n;
        logic [31:0] w;
        n = len_of(len_sel);
        for (int h = 0; h < halves; h++) begin
            w = rand_word(n);
            for (int i = 0; i < t; i++)
                send(h % 2 == 0, (i >= t - n) ? w[t-1-i] : 1'($urandom));
        end
    endtask

    // Multiplexed frame: frame clock high for hi cycles, six words, then filler.
    task automatic mux_frame(input int t, input int hi);
        int n;
        logic [31:0] ws [6];
        n = len_of(len_sel);
        for (int c = 0; c < 6; c++) ws[c] = rand_word(n);
        for (int i = 0; i < t; i++)
            send(i < hi, (i < 6 * n) ? ws[i / n][n - 1 - (i % n)] : 1'($urandom));
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) send(m_last_f, 1'($urandom));
    endtask

    task automatic drain();
        check(expq.size() == 0, "words still due", 32'(expq.size()), 32'd0);
    endtask

    initial begin
        // R1: no word before any frame-clock change.
        do_reset(2'd0, 2'd0);
        cur_req = "R1";
        idle(40);

        // R2 R3 R4 R11: left-justified, 16 bits with filler bits.
        cur_req = "R2 R3 R4 R11";
        lj_run(20, 6);
        idle(5);
        drain();

        // R10: left-justified at 24 and 32 bits, minimum half-frame length.
        do_reset(2'd0, 2'd2);
        cur_req = "R10 R2";
        lj_run(24, 4);
        do_reset(2'd0, 2'd3);
        cur_req = "R10 R3";
        lj_run(40, 4);
        idle(3);
        drain();

        // R7 then R5 R6: right-justified, 16 bits with leading filler.
        do_reset(2'd1, 2'd0);
        cur_req = "R7";
        rj_run(24, 1);
        cur_req = "R5 R6 R11";
        rj_run(24, 6);
        idle(4);
        drain();

        // R5 R10: right-justified at 20 bits exact and at 32 bits.
        do_reset(2'd1, 2'd1);
        cur_req = "R5 R10";
        rj_run(20, 5);
        do_reset(2'd1, 2'd3);
        cur_req = "R6 R10";
        rj_run(36, 5);
        idle(2);
        drain();

        // R8 R9: multiplexed, 16 bits, varying high time and trailing filler.
        do_reset(2'd2, 2'd0);
        cur_req = "R8 R9";
        idle(3);
        mux_frame(6 * 16 + 10, 1);
        mux_frame(6 * 16 + 7, 60);
        mux_frame(6 * 16 + 12, 100);
        idle(4);
        drain();

        // R8: restart in the middle of a burst, then 32-bit back-to-back frames.
        cur_req = "R8 restart";
        mux_frame(40, 3);
        mux_frame(6 * 16, 8);
        do_reset(2'd2, 2'd3);
        cur_req = "R8 R10";
        mux_frame(6 * 32, 16);
        mux_frame(6 * 32, 1);
        idle(3);
        drain();

        // R12: disabled format stays silent under frame-clock activity.
        do_reset(2'd3, 2'd0);
        cur_req = "R12";
        lj_run(20, 4);
        rj_run(20, 2);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog %s: actual=hung expected=finished", cur_req);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule